// File: doc/BRIEF.md
# Prioritised interrupt entry sequencer

This block sits beside the fetch stage of a 16-bit stack processor and decides, at every instruction boundary, whether an interrupt is taken. When the fetch stage flags that a new opcode has arrived, the block ANDs the request lines with the per-line enable bits. If any enabled request is active, it tells the fetch stage to throw that opcode away and to leave IP unchanged. It then takes over the call stack for a short fixed sequence.

The sequence saves two words on the call stack, which grows downward. The first word packs the enable bits together with the carry flag. The second word is the interrupted IP. The block then presents a new IP, a new CSP and a trimmed set of enable bits, together with a one-cycle load strobe that the register file acts on. The new IP comes from a fixed vector table with one small slot per source. Trimming the enables keeps the serviced line and every more urgent line enabled and blocks every less urgent one. All inputs are captured once, when the interrupt is taken, so the sequence is immune to changes that arrive while it runs.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `ip_out` reads 32, `mask_out` reads all zeros, and `upd_valid`, `mem_we` and `busy` are low.
- R2: Bit k of `irq_req` and of `en_mask` belongs to request line k+1. While the block is idle, `suppress` is high in the same cycle as `fetch_strobe` exactly when some line has both its request and its enable set. A request whose enable bit is clear has no effect.
- R3: When several enabled lines are active, the line with the lowest number is serviced.
- R4: In the cycle after an interrupt is taken, `mem_we` is high, `mem_addr` equals the captured CSP minus 2 (modulo 2^16), and `mem_wdata` holds the captured carry in bit 0, the enable bits for lines 1 to 7 in bits 1 to 7, and zeros above.
- R5: In the next cycle, `mem_we` is high again, `mem_addr` equals the captured CSP minus 4, and `mem_wdata` equals the captured IP.
- R6: In the cycle after the second write, `mem_we` is low and `upd_valid` is high for exactly one cycle. At the same time `ip_out` equals 32 plus 4 times the number of the serviced line, and `csp_out` equals the captured CSP minus 4.
- R7: While `upd_valid` is high, `mask_out` holds the captured enable bits for lines 1 up to the serviced line, and zeros for every line numbered higher.
- R8: Requests, enables, carry, IP and CSP are sampled only in the cycle the interrupt is taken. Changes to them later in the sequence do not alter the written words or the update.
- R9: `busy` is high from the cycle after the interrupt is taken through the update cycle. A `fetch_strobe` while busy raises no `suppress` and starts no second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_strobe | input | 1 | A new opcode was fetched this cycle (instruction boundary) |
| irq_req | input | 7 | Request lines; bit k is line k+1 |
| en_mask | input | 7 | Per-line enables; bit k is line k+1 |
| carry_in | input | 1 | Current carry flag |
| ip_in | input | 16 | Current IP (address of the fetched opcode) |
| csp_in | input | 16 | Current call stack pointer |
| suppress | output | 1 | Discard the fetched opcode and hold IP |
| busy | output | 1 | Entry sequence in progress; fetch must wait |
| mem_we | output | 1 | Call-stack memory write enable |
| mem_addr | output | 16 | Call-stack memory byte address |
| mem_wdata | output | 16 | Call-stack memory write data |
| upd_valid | output | 1 | Load `ip_out`, `csp_out`, `mask_out` into the registers |
| ip_out | output | 16 | New IP (vector) |
| csp_out | output | 16 | New call stack pointer |
| mask_out | output | 7 | New per-line enables |

## Verification
The overlap that matters is a fresh instruction boundary landing while an entry is still writing to the call stack. The bench provokes it by raising `fetch_strobe` in the first push cycle. In that same cycle it changes the request lines, the enables, IP and CSP to new values that would select a different line. It then judges that `suppress` stays low and that no second push sequence begins. It also checks that both stored words and the final update still match the values captured when the interrupt was taken, not the new ones.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_MC = 2'd1,
    ST_PUSH_IP = 2'd2,
    ST_LOAD    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/irq_pick.sv
// Fixed-priority picker: the lowest-numbered active line wins.
module irq_pick #(
  parameter int NLINES = 7,
  parameter int IDX_W  = 3
) (
  input  logic [NLINES-1:0] req,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    // Scan from the least urgent line down so the most urgent one writes last.
    for (int k = NLINES - 1; k >= 0; k--) begin
      if (req[k]) idx = IDX_W'(k + 1);
    end
  end

  assign hit = |req;
endmodule

// File: rtl/irq_mask_trim.sv
// Keeps the enables of lines 1..idx and clears every line numbered higher.
module irq_mask_trim #(
  parameter int NLINES = 7,
  parameter int IDX_W  = 3
) (
  input  logic [NLINES-1:0] en,
  input  logic [IDX_W-1:0]  idx,
  output logic [NLINES-1:0] kept
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] LINE_POS = IDX_W'(g);
    // Bit g is line g+1; it survives when g+1 <= idx.
    assign kept[g] = en[g] & (LINE_POS < idx);
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int W        = 16,
  parameter int NLINES   = 7,
  parameter int VEC_BASE = 32,
  parameter int VEC_STEP = 4,
  parameter int WORD_B   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_strobe,
  input  logic [NLINES-1:0] irq_req,
  input  logic [NLINES-1:0] en_mask,
  input  logic              carry_in,
  input  logic [W-1:0]      ip_in,
  input  logic [W-1:0]      csp_in,
  output logic              suppress,
  output logic              busy,
  output logic              mem_we,
  output logic [W-1:0]      mem_addr,
  output logic [W-1:0]      mem_wdata,
  output logic              upd_valid,
  output logic [W-1:0]      ip_out,
  output logic [W-1:0]      csp_out,
  output logic [NLINES-1:0] mask_out
);
  localparam int IDX_W = $clog2(NLINES + 1);
  localparam logic [W-1:0] STEP_B = W'(WORD_B);
  localparam logic [W-1:0] RESET_IP = W'(VEC_BASE);

  seq_state_t state;

  logic [NLINES-1:0] pending;
  logic              pend_hit;
  logic [IDX_W-1:0]  pick_idx;
  logic              take;

  logic [IDX_W-1:0]  idx_q;
  logic [NLINES-1:0] en_q;
  logic [W-1:0]      ip_q;
  logic [W-1:0]      csp_q;
  logic [NLINES-1:0] trimmed;

  assign pending = irq_req & en_mask;

  irq_pick #(.NLINES(NLINES), .IDX_W(IDX_W)) u_pick (
    .req (pending),
    .hit (pend_hit),
    .idx (pick_idx)
  );

  irq_mask_trim #(.NLINES(NLINES), .IDX_W(IDX_W)) u_trim (
    .en   (en_q),
    .idx  (idx_q),
    .kept (trimmed)
  );

  assign take     = fetch_strobe && (state == ST_IDLE) && pend_hit;
  assign suppress = take;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx_q     <= '0;
      en_q      <= '0;
      ip_q      <= '0;
      csp_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      upd_valid <= 1'b0;
      ip_out    <= RESET_IP;
      csp_out   <= '0;
      mask_out  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            // Capture everything once; the rest of the sequence uses copies.
            idx_q     <= pick_idx;
            en_q      <= en_mask;
            ip_q      <= ip_in;
            csp_q     <= csp_in;
            mem_we    <= 1'b1;
            mem_addr  <= csp_in - STEP_B;
            mem_wdata <= W'({en_mask, carry_in});
            state     <= ST_PUSH_MC;
          end
        end
        ST_PUSH_MC: begin
          mem_we    <= 1'b1;
          mem_addr  <= csp_q - (STEP_B << 1);
          mem_wdata <= ip_q;
          state     <= ST_PUSH_IP;
        end
        ST_PUSH_IP: begin
          mem_we    <= 1'b0;
          upd_valid <= 1'b1;
          ip_out    <= W'(VEC_BASE + VEC_STEP * int'(idx_q));
          csp_out   <= csp_q - (STEP_B << 1);
          mask_out  <= trimmed;
          state     <= ST_LOAD;
        end
        default: begin
          upd_valid <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // A taken interrupt starts the first push on the next cycle.
  assert_take_starts_push_R2: assert property (@(posedge clk) disable iff (rst)
    suppress |=> (busy && mem_we));

  // The second push lands one word below the first.
  assert_push_order_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && state == ST_PUSH_MC) |=> (mem_we && mem_addr == $past(mem_addr) - STEP_B));

  // The update follows directly after a write cycle and no write overlaps it.
  assert_update_after_push_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> ($past(mem_we) && !mem_we));

  // The new CSP is the address of the last word written.
  assert_csp_matches_last_write_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (csp_out == $past(mem_addr)));

  // The load strobe lasts one cycle.
  assert_single_update_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid);

  // Trimming only clears enables, never sets one.
  assert_trim_only_clears_R7: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> ((mask_out & ~en_q) == '0));

  // A boundary seen while busy is never suppressed.
  assert_no_reentry_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && fetch_strobe) |-> !suppress);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int W = 16;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fetch_strobe = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [N-1:0] en_mask = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] ip_in = '0;
  logic [W-1:0] csp_in = '0;
  logic         suppress, busy, mem_we, upd_valid;
  logic [W-1:0] mem_addr, mem_wdata, ip_out, csp_out;
  logic [N-1:0] mask_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .fetch_strobe(fetch_strobe), .irq_req(irq_req),
    .en_mask(en_mask), .carry_in(carry_in), .ip_in(ip_in), .csp_in(csp_in),
    .suppress(suppress), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .upd_valid(upd_valid), .ip_out(ip_out),
    .csp_out(csp_out), .mask_out(mask_out)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int first_line(input logic [N-1:0] p);
    for (int k = 0; k < N; k++) if (p[k]) return k + 1;
    return 0;
  endfunction

  function automatic logic [N-1:0] keep_upto(input logic [N-1:0] en, input int line);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = en[k] && (k + 1 <= line);
    return r;
  endfunction

  // Drives one boundary; when disturb is set, scrambles inputs and
  // raises a second boundary during the first push.
  task automatic run_entry(input logic [N-1:0] rq, input logic [N-1:0] en,
                           input logic c, input logic [W-1:0] ip,
                           input logic [W-1:0] csp, input bit disturb);
    logic [N-1:0] pend;
    int line;
    pend = rq & en;
    line = first_line(pend);
    @(negedge clk);
    irq_req = rq; en_mask = en; carry_in = c; ip_in = ip; csp_in = csp;
    fetch_strobe = 1'b1;
    #1;
    check(suppress == (pend != 0), "R2 suppress", int'(suppress), int'(pend != 0));
    @(negedge clk);
    fetch_strobe = 1'b0;
    if (line == 0) begin
      for (int i = 0; i < 3; i++) begin
        #1;
        check(!mem_we && !upd_valid && !busy, "R2 masked request ignored",
              int'({mem_we, upd_valid, busy}), 0);
        @(negedge clk);
      end
      return;
    end
    if (disturb) begin
      irq_req = '1; en_mask = '1; carry_in = ~c; ip_in = ~ip; csp_in = csp + 16'h0100;
      fetch_strobe = 1'b1;
    end
    #1;
    if (disturb) check(!suppress, "R9 boundary while busy", int'(suppress), 0);
    check(busy, "R9 busy in first push", int'(busy), 1);
    check(mem_we && mem_addr == W'(csp - 16'd2), "R4 first push address",
          int'(mem_addr), int'(W'(csp - 16'd2)));
    check(mem_wdata == W'({en, c}), "R4 mask/carry word", int'(mem_wdata), int'(W'({en, c})));
    @(negedge clk);
    fetch_strobe = 1'b0;
    #1;
    check(mem_we && mem_addr == W'(csp - 16'd4), "R5 second push address",
          int'(mem_addr), int'(W'(csp - 16'd4)));
    check(mem_wdata == ip, disturb ? "R8 saved IP unchanged" : "R5 saved IP",
          int'(mem_wdata), int'(ip));
    @(negedge clk);
    #1;
    check(upd_valid && !mem_we && busy, "R6 update strobe", int'({upd_valid, mem_we, busy}), 5);
    check(ip_out == W'(32 + 4 * line), "R3 R6 vector", int'(ip_out), 32 + 4 * line);
    check(csp_out == W'(csp - 16'd4), "R6 new CSP", int'(csp_out), int'(W'(csp - 16'd4)));
    check(mask_out == keep_upto(en, line), disturb ? "R8 R7 trimmed mask" : "R7 trimmed mask",
          int'(mask_out), int'(keep_upto(en, line)));
    @(negedge clk);
    #1;
    check(!upd_valid && !busy && !mem_we, "R6 R9 sequence ends", int'({upd_valid, busy, mem_we}), 0);
    irq_req = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rq, en;
    void'($urandom(32'd20211122));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(ip_out == 16'd32, "R1 reset IP", int'(ip_out), 32);
    check(mask_out == '0, "R1 reset mask", int'(mask_out), 0);
    check(!upd_valid && !mem_we && !busy, "R1 reset strobes", int'({upd_valid, mem_we, busy}), 0);

    run_entry(7'h7F, 7'h00, 1'b1, 16'h1234, 16'h0700, 1'b0);   // all masked
    run_entry(7'h7F, 7'h7F, 1'b0, 16'h0444, 16'h0700, 1'b0);   // line 1 wins
    run_entry(7'h40, 7'h7F, 1'b1, 16'hBEEE, 16'h0000, 1'b0);   // line 7, CSP wraps
    run_entry(7'h5C, 7'h58, 1'b1, 16'h2222, 16'h8002, 1'b0);   // line 4 through mask
    run_entry(7'h24, 7'h3F, 1'b0, 16'h0AA0, 16'h0600, 1'b1);   // inputs disturbed
    run_entry(7'h00, 7'h7F, 1'b1, 16'h0100, 16'h0600, 1'b0);   // no request

    for (int i = 0; i < 60; i++) begin
      rq = N'($urandom);
      en = N'($urandom);
      run_entry(rq, en, 1'($urandom), {W'($urandom)} & 16'hFFFE,
                {W'($urandom)} & 16'hFFFE, ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule